// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block keeps a small table of branch targets for an instruction fetch stage. Fetch presents its current PC on the lookup port. In the same cycle the block reports three things: whether the selected slot holds an entry, whether that entry belongs to this PC, and the target stored in the slot. When a branch resolves later in the pipeline, the update port writes the branch PC and its target into the slot that the PC selects. Any previous occupant of that slot is replaced.

The slot is chosen by the PC modulo the entry count, which is a power-of-two parameter. Each slot keeps the complete PC as its tag, so two PCs that share a slot never alias into a false hit. A third port rewrites only the tag of an occupied slot and leaves its target in place. This lets a known target be moved over to a different branch address without writing it again.

Top module: `btb_direct`

## Requirements
- R1: After reset every slot is empty, so each lookup returns lk_valid=0, lk_hit=0 and lk_target=0.
- R2: The slot for a PC is the PC modulo ENTRIES, which is its low log2(ENTRIES) bits. PCs that differ only above those bits share a slot.
- R3: lk_hit is 1 only when the selected slot is occupied and its stored tag equals lk_pc in all PC_W bits.
- R4: A cycle with up_en=1 stores up_pc as the tag and up_target as the target in the slot of up_pc, and marks the slot occupied. Lookups see the new contents from the next clock edge on.
- R5: A full update overwrites an occupied slot unconditionally. The PC that was stored before no longer hits.
- R6: A tag-only write (tg_en=1) into an occupied slot replaces the slot's tag with tg_tag and keeps its stored target.
- R7: A tag-only write into an empty slot has no effect, and the slot stays empty.
- R8: Lookup is combinational. If a write and a lookup select the same slot in one cycle, the lookup returns the contents from before the write.
- R9: When up_en and tg_en are both 1 in the same cycle, only the full update is performed and the tag-only write is dropped.
- R10: lk_valid shows whether the selected slot is occupied, whatever its tag. lk_target shows that slot's stored target, and is 0 when the slot is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears every slot |
| lk_pc | input | PC_W | PC for the lookup |
| lk_valid | output | 1 | Selected slot is occupied |
| lk_hit | output | 1 | Selected slot is occupied and its tag equals lk_pc |
| lk_target | output | TGT_W | Target stored in the selected slot (0 if empty) |
| up_en | input | 1 | Full update request |
| up_pc | input | PC_W | Branch PC; selects the slot and becomes its tag |
| up_target | input | TGT_W | Resolved branch target |
| tg_en | input | 1 | Tag-only update request |
| tg_pc | input | PC_W | PC that selects the slot for a tag rewrite |
| tg_tag | input | PC_W | New tag value |

## Verification
Two pairs of operations can fall in the same cycle: a write with a lookup of the same slot, and a full update with a tag-only write. The bench causes the first by presenting lk_pc during the cycle an update to that slot is pending, and checks that the old target is reported. It then checks that the new one appears after the edge. For the second, it raises both update enables together, once on different slots and once on one shared slot. Afterwards it looks up both the old and the new tags, to confirm that only the full update took effect.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_FULL = 2'd1,
        WR_TAG  = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/btb_slot_sel.sv
module btb_slot_sel #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 2) ? $clog2(ENTRIES) : 1
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = IDX_W'(pc % PC_W'(ENTRIES));
    end

endmodule

// File: rtl/btb_wr_arb.sv
module btb_wr_arb
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int TGT_W   = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 2) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TGT_W-1:0] up_target,
    input  logic             tg_en,
    input  logic [IDX_W-1:0] tg_idx,
    input  logic [PC_W-1:0]  tg_tag,
    input  logic             tg_slot_valid,
    output wr_kind_e         wr_kind,
    output logic [IDX_W-1:0] wr_idx,
    output logic [PC_W-1:0]  wr_tag,
    output logic [TGT_W-1:0] wr_tgt
);

    typedef struct packed {
        wr_kind_e         kind;
        logic [IDX_W-1:0] idx;
        logic [PC_W-1:0]  tag;
        logic [TGT_W-1:0] tgt;
    } wr_cmd_t;

    wr_cmd_t cmd_d;

    always_comb begin
        cmd_d = '{kind: WR_NONE, idx: '0, tag: '0, tgt: '0};
        if (up_en) begin
            cmd_d.kind = WR_FULL;
            cmd_d.idx  = up_idx;
            cmd_d.tag  = up_pc;
            cmd_d.tgt  = up_target;
        end else if (tg_en && tg_slot_valid) begin
            cmd_d.kind = WR_TAG;
            cmd_d.idx  = tg_idx;
            cmd_d.tag  = tg_tag;
        end
    end

    assign wr_kind = cmd_d.kind;
    assign wr_idx  = cmd_d.idx;
    assign wr_tag  = cmd_d.tag;
    assign wr_tgt  = cmd_d.tgt;

    // R9: a full request always wins the write slot
    p_full_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && tg_en) |-> (wr_kind == WR_FULL && wr_tag == up_pc));

    // R7: a tag rewrite never targets an empty slot
    p_no_tag_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_en && !up_en && !tg_slot_valid) |-> (wr_kind == WR_NONE));

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int TGT_W   = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 2) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_kind_e         wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_valid
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][PC_W-1:0]   tag;
        logic [ENTRIES-1:0][TGT_W-1:0]  tgt;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        case (wr_kind)
            WR_FULL: begin
                tbl_d.valid[wr_idx] = 1'b1;
                tbl_d.tag[wr_idx]   = wr_tag;
                tbl_d.tgt[wr_idx]   = wr_tgt;
            end
            WR_TAG: begin
                if (tbl_q.valid[wr_idx]) begin
                    tbl_d.tag[wr_idx] = wr_tag;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_valid    = tbl_q.valid[rd_idx];
    assign rd_tag      = tbl_q.tag[rd_idx];
    assign rd_tgt      = tbl_q.tgt[rd_idx];
    assign probe_valid = tbl_q.valid[probe_idx];

    // R4: a full write lands complete on the next edge
    p_full_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_FULL) |=> (tbl_q.valid[$past(wr_idx)]
                                  && tbl_q.tag[$past(wr_idx)] == $past(wr_tag)
                                  && tbl_q.tgt[$past(wr_idx)] == $past(wr_tgt)));

    // R6: a tag rewrite leaves the stored target alone
    p_tag_keeps_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_TAG) |=> (tbl_q.tgt[$past(wr_idx)] == $past(tbl_q.tgt[wr_idx])));

    // R7: an empty slot stays empty through a tag rewrite
    p_empty_stays_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == WR_TAG && !tbl_q.valid[wr_idx]) |=> !tbl_q.valid[$past(wr_idx)]);

    // R1: slots only become occupied through a full write
    p_valid_only_by_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind != WR_FULL) |=> (tbl_q.valid == $past(tbl_q.valid)));

endmodule

// File: rtl/btb_direct.sv
module btb_direct
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int TGT_W   = 32,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_valid,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TGT_W-1:0] up_target,
    input  logic             tg_en,
    input  logic [PC_W-1:0]  tg_pc,
    input  logic [PC_W-1:0]  tg_tag
);

    localparam int IDX_W   = (ENTRIES > 2) ? $clog2(ENTRIES) : 1;
    localparam int N_PORTS = 3;
    localparam int P_LK    = 0;
    localparam int P_UP    = 1;
    localparam int P_TG    = 2;

    logic [N_PORTS-1:0][PC_W-1:0]  port_pc;
    logic [N_PORTS-1:0][IDX_W-1:0] port_idx;

    assign port_pc[P_LK] = lk_pc;
    assign port_pc[P_UP] = up_pc;
    assign port_pc[P_TG] = tg_pc;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_sel
        btb_slot_sel #(
            .PC_W    (PC_W),
            .ENTRIES (ENTRIES)
        ) u_sel (
            .pc  (port_pc[g]),
            .idx (port_idx[g])
        );
    end

    wr_kind_e         wr_kind;
    logic [IDX_W-1:0] wr_idx;
    logic [PC_W-1:0]  wr_tag;
    logic [TGT_W-1:0] wr_tgt;
    logic             rd_valid;
    logic [PC_W-1:0]  rd_tag;
    logic [TGT_W-1:0] rd_tgt;
    logic             tg_slot_valid;

    btb_wr_arb #(
        .PC_W    (PC_W),
        .TGT_W   (TGT_W),
        .ENTRIES (ENTRIES)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_en         (up_en),
        .up_idx        (port_idx[P_UP]),
        .up_pc         (up_pc),
        .up_target     (up_target),
        .tg_en         (tg_en),
        .tg_idx        (port_idx[P_TG]),
        .tg_tag        (tg_tag),
        .tg_slot_valid (tg_slot_valid),
        .wr_kind       (wr_kind),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .wr_tgt        (wr_tgt)
    );

    btb_store #(
        .PC_W    (PC_W),
        .TGT_W   (TGT_W),
        .ENTRIES (ENTRIES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_kind     (wr_kind),
        .wr_idx      (wr_idx),
        .wr_tag      (wr_tag),
        .wr_tgt      (wr_tgt),
        .rd_idx      (port_idx[P_LK]),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_tag),
        .rd_tgt      (rd_tgt),
        .probe_idx   (port_idx[P_TG]),
        .probe_valid (tg_slot_valid)
    );

    always_comb begin
        lk_valid  = rd_valid;
        lk_hit    = rd_valid && (rd_tag == lk_pc);
        lk_target = rd_valid ? rd_tgt : '0;
    end

    // R3: no hit without an occupied slot
    p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    // R10: empty slot presents a zero target
    p_empty_zero_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (lk_target == '0));

    // R8: with no write pending, a held lookup gives a held answer
    p_lookup_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_en && !tg_en) ##1 $stable(lk_pc) |-> $stable(lk_hit) && $stable(lk_target));

endmodule

// File: tb/btb_direct_test.sv
module btb_direct_test;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int TGT_W      = 32;
    localparam int ENTRIES    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_valid;
    logic             lk_hit;
    logic [TGT_W-1:0] lk_target;
    logic             up_en = 1'b0;
    logic [PC_W-1:0]  up_pc = '0;
    logic [TGT_W-1:0] up_target = '0;
    logic             tg_en = 1'b0;
    logic [PC_W-1:0]  tg_pc = '0;
    logic [PC_W-1:0]  tg_tag = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_direct #(
        .PC_W    (PC_W),
        .TGT_W   (TGT_W),
        .ENTRIES (ENTRIES)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_valid  (lk_valid),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .up_en     (up_en),
        .up_pc     (up_pc),
        .up_target (up_target),
        .tg_en     (tg_en),
        .tg_pc     (tg_pc),
        .tg_tag    (tg_tag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // present a PC between edges and compare all three lookup outputs
    task automatic look(input string req, input logic [PC_W-1:0] pc,
                        input logic v, input logic h, input logic [TGT_W-1:0] t);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check({req, " valid"},  64'(lk_valid),  64'(v));
        check({req, " hit"},    64'(lk_hit),    64'(h));
        check({req, " target"}, 64'(lk_target), 64'(t));
    endtask

    task automatic full_write(input logic [PC_W-1:0] pc, input logic [TGT_W-1:0] t);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_target = t;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic tag_write(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tag);
        @(negedge clk);
        tg_en = 1'b1; tg_pc = pc; tg_tag = tag;
        @(negedge clk);
        tg_en = 1'b0;
    endtask

    task automatic t_reset_r1;
        for (int i = 0; i < 3; i++) begin
            look("R1", PC_W'(i * 7), 1'b0, 1'b0, '0);
        end
    endtask

    task automatic t_full_write_r4;
        full_write(32'h0000_0100, 32'h0000_AAAA);
        look("R4", 32'h0000_0100, 1'b1, 1'b1, 32'h0000_AAAA);
        look("R2 neighbour slot", 32'h0000_0101, 1'b0, 1'b0, '0);
    endtask

    task automatic t_shared_slot_r2;
        full_write(32'h0000_0023, 32'h0000_1234);
        // 0x33 selects slot 3 too but carries another tag
        look("R2 R3 R10", 32'h0000_0033, 1'b1, 1'b0, 32'h0000_1234);
        look("R3 high bit tag", 32'h8000_0023, 1'b1, 1'b0, 32'h0000_1234);
    endtask

    task automatic t_overwrite_r5;
        full_write(32'h0000_0033, 32'h0000_5678);
        look("R5 evicted", 32'h0000_0023, 1'b1, 1'b0, 32'h0000_5678);
        look("R5 new", 32'h0000_0033, 1'b1, 1'b1, 32'h0000_5678);
    endtask

    task automatic t_tag_only_r6;
        tag_write(32'h0000_0033, 32'h0000_0043);
        look("R6 new tag", 32'h0000_0043, 1'b1, 1'b1, 32'h0000_5678);
        look("R6 old tag", 32'h0000_0033, 1'b1, 1'b0, 32'h0000_5678);
    endtask

    task automatic t_tag_empty_r7;
        tag_write(32'h0000_0005, 32'h0000_0005);
        look("R7", 32'h0000_0005, 1'b0, 1'b0, '0);
    endtask

    task automatic t_same_cycle_r8;
        full_write(32'h0000_0007, 32'h0000_0077);
        @(negedge clk);
        up_en = 1'b1; up_pc = 32'h0000_0017; up_target = 32'h0000_0099;
        lk_pc = 32'h0000_0007;
        #1;
        check("R8 old hit",    64'(lk_hit),    64'(1'b1));
        check("R8 old target", 64'(lk_target), 64'(32'h0000_0077));
        @(negedge clk);
        up_en = 1'b0;
        look("R8 after edge", 32'h0000_0017, 1'b1, 1'b1, 32'h0000_0099);
    endtask

    task automatic t_priority_r9;
        // different slots: tag rewrite on slot 7 must be dropped
        @(negedge clk);
        up_en = 1'b1; up_pc = 32'h0000_0009; up_target = 32'h0000_0909;
        tg_en = 1'b1; tg_pc = 32'h0000_0017; tg_tag = 32'h0000_0027;
        @(negedge clk);
        up_en = 1'b0; tg_en = 1'b0;
        look("R9 tag dropped", 32'h0000_0017, 1'b1, 1'b1, 32'h0000_0099);
        look("R9 full done", 32'h0000_0009, 1'b1, 1'b1, 32'h0000_0909);
        // same slot 10
        full_write(32'h0000_001A, 32'h0000_1A1A);
        @(negedge clk);
        up_en = 1'b1; up_pc = 32'h0000_002A; up_target = 32'h0000_2A2A;
        tg_en = 1'b1; tg_pc = 32'h0000_002A; tg_tag = 32'h0000_003A;
        @(negedge clk);
        up_en = 1'b0; tg_en = 1'b0;
        look("R9 same slot", 32'h0000_002A, 1'b1, 1'b1, 32'h0000_2A2A);
        look("R9 no retag", 32'h0000_003A, 1'b1, 1'b0, 32'h0000_2A2A);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_reset_r1();
        t_full_write_r4();
        t_shared_slot_r2();
        t_overwrite_r5();
        t_tag_only_r6();
        t_tag_empty_r7();
        t_same_cycle_r8();
        t_priority_r9();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule